// File: doc/BRIEF.md
# Port C Control Word Decoder and Bit Set/Reset Register

This block decodes control-address writes for a three-port parallel interface and holds the shared port-C output latch. A control byte with bit 7 high is a configuration word. It sets the operating mode of port A (basic, strobed or bidirectional), its direction, the mode and direction of port B, and the direction of each port-C nibble. A control byte with bit 7 low is a single-bit command. It sets or clears one port-C position.

Direct data writes to port C are masked pin by pin. Only spare pins that are outputs and belong to a port running in basic mode accept them. Handshake pins and spare pins next to a strobed port can only be changed by single-bit commands. A single-bit command that hits the strobe/acknowledge input of a strobed port updates that port's interrupt-enable flag and leaves the latch alone. On a configuration word the latch is rebuilt: output pins are cleared, output-buffer-full positions are set, and every interrupt enable is cleared. The sequencer then raises `hs_init` for one cycle so that the handshake blocks restart.

The sequencer has three states. `ST_BOOT` is held during reset and lasts one cycle after release. `ST_IDLE` is the resting state. `ST_APPLY` lasts one cycle after any configuration word. The transitions are: BOOT→IDLE on the first clock after reset, IDLE→APPLY or APPLY→APPLY on a configuration word, and APPLY→IDLE otherwise. `hs_init` is high in BOOT and APPLY.

Top module: `portc_ctrl`

## Requirements
- R1: During reset, and until the first clock edge after release, the block reports this state: port A basic mode as input, port B basic mode as input, both nibbles input, `pc_out_en`=0x00, `pc_out`=0x00, all interrupt enables 0, and `hs_init`=1. One edge after release, `hs_init`=0.
- R2: The fields of a configuration word (bit 7 = 1) map as follows. Port A mode comes from bits 6:5: 00 gives basic (0), 01 gives strobed (1), and 1x gives bidirectional (2). Bit 4 = 1 makes port A an input. Bit 3 = 1 makes the upper nibble an input. Bit 2 = 1 makes port B strobed. Bit 1 = 1 makes port B an input. Bit 0 = 1 makes the lower nibble an input.
- R3: In a single-bit command (bit 7 = 0), bits 3:1 select the position, bit 0 gives the value, and bits 6:4 are ignored. The command changes the latch only at positions where `pc_out_en` is 1, and that includes handshake outputs.
- R4: A direct port-C write changes only spare output pins. The upper nibble is locked while port A is strobed or bidirectional. The lower nibble is locked while port B is strobed.
- R5: `pc_out_en` marks the handshake outputs plus the spare pins whose nibble is an output. Port A strobed input drives 3 and 5 and reads 4. Port A strobed output drives 3 and 7 and reads 6. Port A bidirectional drives 3, 5 and 7 and reads 4 and 6. Port B strobed drives 0 and 1 and reads 2.
- R6: After a configuration word, `pc_out` is 0 except at output-buffer-full positions, which are 1. These positions are bit 7 when port A is a strobed output or bidirectional, and bit 1 when port B is a strobed output.
- R7: Some single-bit commands go to interrupt-enable flags instead of the latch. Position 4 goes to `inte_a_rx` when port A is a strobed input or bidirectional. Position 6 goes to `inte_a_tx` when port A is a strobed output or bidirectional. Position 2 goes to `inte_b` when port B is strobed. A configuration word clears all three flags.
- R8: `hs_init` is high for exactly the one cycle after each configuration word.
- R9: `pc_rd_data` returns the latch value at output positions and `pc_pin_in` at all other positions.
- R10: If a control write and a direct port-C write arrive in the same cycle, the control write takes effect and the data write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Write strobe for the control address |
| portc_wr | input | 1 | Write strobe for the port-C data address |
| wr_data | input | 8 | Write data |
| pc_pin_in | input | 8 | Sampled port-C pin levels |
| pc_out | output | 8 | Port-C drive values (latch masked by output enable) |
| pc_out_en | output | 8 | Per-pin output enable |
| pc_rd_data | output | 8 | Host read value of port C |
| a_mode | output | 2 | Port A mode: 0 basic, 1 strobed, 2 bidirectional |
| a_is_input | output | 1 | Port A direction is input |
| b_is_strobed | output | 1 | Port B in strobed mode |
| b_is_input | output | 1 | Port B direction is input |
| inte_a_rx | output | 1 | Port A input-side interrupt enable |
| inte_a_tx | output | 1 | Port A output-side interrupt enable |
| inte_b | output | 1 | Port B interrupt enable |
| hs_init | output | 1 | One-cycle restart pulse for the handshake blocks |

## Verification
The assertions check several properties on every cycle. A direct write never touches a bit outside the writable mask. An ignored single-bit command leaves the latch untouched. A configuration word rebuilds the driven latch bits to exactly the output-buffer-full pattern and clears the enables. Interrupt enables hold between control writes. `hs_init` is a single pulse. Only the directed scenarios can show the field decoding, the pin-role map for each mode, the read mux with real pin levels, and the priority when both write strobes arrive in the same cycle.

// File: rtl/portc_pkg.sv
package portc_pkg;
    localparam int PC_W = 8;
    localparam int NIB  = PC_W / 2;

    localparam int POS_B_INTR = 0;
    localparam int POS_B_FLAG = 1;
    localparam int POS_B_STB  = 2;
    localparam int POS_A_INTR = 3;
    localparam int POS_A_STB  = 4;
    localparam int POS_A_IBF  = 5;
    localparam int POS_A_ACK  = 6;
    localparam int POS_A_OBF  = 7;

    typedef enum logic [1:0] {
        AM_BASIC    = 2'd0,
        AM_STROBED  = 2'd1,
        AM_BIDIR    = 2'd2
    } a_mode_e;

    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_APPLY = 2'd2
    } seq_state_e;

    typedef struct packed {
        a_mode_e a_mode;
        logic    a_in;
        logic    hi_in;
        logic    b_strobed;
        logic    b_in;
        logic    lo_in;
    } cfg_t;

    typedef struct packed {
        logic [PC_W-1:0] out_mask;
        logic [PC_W-1:0] gpio_mask;
        logic [PC_W-1:0] obf_mask;
        logic            rx_ok;
        logic            tx_ok;
        logic            b_ok;
    } roles_t;

    localparam cfg_t CFG_RESET = '{a_mode: AM_BASIC, a_in: 1'b1, hi_in: 1'b1,
                                   b_strobed: 1'b0, b_in: 1'b1, lo_in: 1'b1};

    function automatic cfg_t decode_word(logic [6:0] w);
        cfg_t c;
        c.a_mode    = w[6] ? AM_BIDIR : (w[5] ? AM_STROBED : AM_BASIC);
        c.a_in      = w[4];
        c.hi_in     = w[3];
        c.b_strobed = w[2];
        c.b_in      = w[1];
        c.lo_in     = w[0];
        return c;
    endfunction

    function automatic roles_t role_of(cfg_t c);
        roles_t          r;
        logic [PC_W-1:0] hs_out;
        logic [PC_W-1:0] hs_in;
        logic [PC_W-1:0] dir_out;
        logic [PC_W-1:0] spare;
        logic [PC_W-1:0] lock;
        hs_out = '0;
        hs_in  = '0;
        r      = '0;
        unique case (c.a_mode)
            AM_BASIC: begin
            end
            AM_STROBED: begin
                hs_out[POS_A_INTR] = 1'b1;
                if (c.a_in) begin
                    hs_out[POS_A_IBF] = 1'b1;
                    hs_in[POS_A_STB]  = 1'b1;
                    r.rx_ok           = 1'b1;
                end else begin
                    hs_out[POS_A_OBF]     = 1'b1;
                    hs_in[POS_A_ACK]      = 1'b1;
                    r.obf_mask[POS_A_OBF] = 1'b1;
                    r.tx_ok               = 1'b1;
                end
            end
            AM_BIDIR: begin
                hs_out[POS_A_INTR]    = 1'b1;
                hs_out[POS_A_IBF]     = 1'b1;
                hs_out[POS_A_OBF]     = 1'b1;
                hs_in[POS_A_STB]      = 1'b1;
                hs_in[POS_A_ACK]      = 1'b1;
                r.obf_mask[POS_A_OBF] = 1'b1;
                r.rx_ok               = 1'b1;
                r.tx_ok               = 1'b1;
            end
            default: begin
            end
        endcase
        if (c.b_strobed) begin
            hs_out[POS_B_INTR] = 1'b1;
            hs_out[POS_B_FLAG] = 1'b1;
            hs_in[POS_B_STB]   = 1'b1;
            r.b_ok             = 1'b1;
            if (!c.b_in) r.obf_mask[POS_B_FLAG] = 1'b1;
        end
        dir_out     = {{NIB{~c.hi_in}}, {NIB{~c.lo_in}}};
        spare       = dir_out & ~(hs_out | hs_in);
        lock        = {{NIB{c.a_mode != AM_BASIC}}, {NIB{c.b_strobed}}};
        r.out_mask  = hs_out | spare;
        r.gpio_mask = spare & ~lock;
        return r;
    endfunction

    function automatic logic [PC_W-1:0] entry_image(cfg_t c, logic [PC_W-1:0] old);
        roles_t r;
        r = role_of(c);
        return (old & ~r.out_mask) | r.obf_mask;
    endfunction
endpackage

// File: rtl/portc_seq.sv
module portc_seq
    import portc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_wr,
    output logic hs_init
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:  state_d = mode_wr ? ST_APPLY : ST_IDLE;
            ST_IDLE:  state_d = mode_wr ? ST_APPLY : ST_IDLE;
            ST_APPLY: state_d = mode_wr ? ST_APPLY : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_BOOT, ST_APPLY: hs_init = 1'b1;
            default:           hs_init = 1'b0;
        endcase
    end

    p_apply_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> hs_init);
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hs_init && !mode_wr |=> !hs_init);
endmodule

// File: rtl/portc_latch.sv
module portc_latch
    import portc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctrl_wr,
    input  logic            data_wr,
    input  logic [PC_W-1:0] wr_data,
    input  roles_t          cur,
    input  logic [PC_W-1:0] entry_val,
    output logic [PC_W-1:0] latch_q,
    output logic            inte_rx_q,
    output logic            inte_tx_q,
    output logic            inte_b_q
);
    logic       is_mode, is_bsr, bit_val;
    logic [2:0] idx;
    logic       hit_rx, hit_tx, hit_b, inte_hit;

    assign is_mode  = ctrl_wr & wr_data[7];
    assign is_bsr   = ctrl_wr & ~wr_data[7];
    assign idx      = wr_data[3:1];
    assign bit_val  = wr_data[0];
    assign hit_rx   = is_bsr && (idx == 3'(POS_A_STB)) && cur.rx_ok;
    assign hit_tx   = is_bsr && (idx == 3'(POS_A_ACK)) && cur.tx_ok;
    assign hit_b    = is_bsr && (idx == 3'(POS_B_STB)) && cur.b_ok;
    assign inte_hit = hit_rx | hit_tx | hit_b;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q   <= '0;
            inte_rx_q <= 1'b0;
            inte_tx_q <= 1'b0;
            inte_b_q  <= 1'b0;
        end else if (is_mode) begin
            latch_q   <= entry_val;
            inte_rx_q <= 1'b0;
            inte_tx_q <= 1'b0;
            inte_b_q  <= 1'b0;
        end else if (is_bsr) begin
            if (hit_rx)                  inte_rx_q    <= bit_val;
            else if (hit_tx)             inte_tx_q    <= bit_val;
            else if (hit_b)              inte_b_q     <= bit_val;
            else if (cur.out_mask[idx])  latch_q[idx] <= bit_val;
        end else if (data_wr) begin
            latch_q <= (latch_q & ~cur.gpio_mask) | (wr_data & cur.gpio_mask);
        end
    end

    p_bsr_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_bsr && !cur.out_mask[idx] && !inte_hit |=> $stable(latch_q));
    p_direct_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr && !ctrl_wr |=> ((latch_q ^ $past(latch_q)) & ~$past(cur.gpio_mask)) == '0);
    p_entry_image_r6: assert property (@(posedge clk) disable iff (!rst_n)
        is_mode |=> (latch_q & cur.out_mask) == cur.obf_mask);
    p_inte_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        is_mode |=> !inte_rx_q && !inte_tx_q && !inte_b_q);
    p_inte_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable({inte_rx_q, inte_tx_q, inte_b_q}));
endmodule

// File: rtl/portc_rdmux.sv
module portc_rdmux #(
    parameter int W = 8
) (
    input  logic [W-1:0] drive_en,
    input  logic [W-1:0] latch_val,
    input  logic [W-1:0] pin_val,
    output logic [W-1:0] rd_val
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign rd_val[i] = drive_en[i] ? latch_val[i] : pin_val[i];
    end
endmodule

// File: rtl/portc_ctrl.sv
module portc_ctrl
    import portc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctrl_wr,
    input  logic            portc_wr,
    input  logic [PC_W-1:0] wr_data,
    input  logic [PC_W-1:0] pc_pin_in,
    output logic [PC_W-1:0] pc_out,
    output logic [PC_W-1:0] pc_out_en,
    output logic [PC_W-1:0] pc_rd_data,
    output logic [1:0]      a_mode,
    output logic            a_is_input,
    output logic            b_is_strobed,
    output logic            b_is_input,
    output logic            inte_a_rx,
    output logic            inte_a_tx,
    output logic            inte_b,
    output logic            hs_init
);
    cfg_t            cfg_q, cfg_new;
    roles_t          cur;
    logic            mode_wr;
    logic [PC_W-1:0] latch_q, entry_val;

    assign mode_wr   = ctrl_wr & wr_data[7];
    assign cfg_new   = decode_word(wr_data[6:0]);
    assign cur       = role_of(cfg_q);
    assign entry_val = entry_image(cfg_new, latch_q);

    always_ff @(posedge clk) begin
        if (!rst_n)       cfg_q <= CFG_RESET;
        else if (mode_wr) cfg_q <= cfg_new;
    end

    portc_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_wr (mode_wr),
        .hs_init (hs_init)
    );

    portc_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .data_wr   (portc_wr),
        .wr_data   (wr_data),
        .cur       (cur),
        .entry_val (entry_val),
        .latch_q   (latch_q),
        .inte_rx_q (inte_a_rx),
        .inte_tx_q (inte_a_tx),
        .inte_b_q  (inte_b)
    );

    portc_rdmux #(.W(PC_W)) u_rdmux (
        .drive_en  (cur.out_mask),
        .latch_val (latch_q),
        .pin_val   (pc_pin_in),
        .rd_val    (pc_rd_data)
    );

    assign pc_out_en    = cur.out_mask;
    assign pc_out       = latch_q & cur.out_mask;
    assign a_mode       = cfg_q.a_mode;
    assign a_is_input   = cfg_q.a_in;
    assign b_is_strobed = cfg_q.b_strobed;
    assign b_is_input   = cfg_q.b_in;
endmodule

// File: tb/test_portc_ctrl.sv
`timescale 1ns/100ps
module test_portc_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_wr = 1'b0, portc_wr = 1'b0;
    logic [7:0] wr_data = '0, pc_pin_in = '0;
    logic [7:0] pc_out, pc_out_en, pc_rd_data;
    logic [1:0] a_mode;
    logic       a_is_input, b_is_strobed, b_is_input;
    logic       inte_a_rx, inte_a_tx, inte_b, hs_init;
    int         checks = 0, fails = 0;
    bit         done = 0;

    always #2.5 clk = ~clk;

    portc_ctrl i_portc_ctrl (.*);

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ctl(logic [7:0] d);
        @(negedge clk); ctrl_wr = 1'b1; wr_data = d;
        @(negedge clk); ctrl_wr = 1'b0;
    endtask

    task automatic pcw(logic [7:0] d);
        @(negedge clk); portc_wr = 1'b1; wr_data = d;
        @(negedge clk); portc_wr = 1'b0;
    endtask

    task automatic mode_word(logic [7:0] d);
        ctl(d);
        chk("R8 pulse", 8'(hs_init), 8'h1);
        @(negedge clk);
        chk("R8 single", 8'(hs_init), 8'h0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R1 out_en", pc_out_en, 8'h00);
        chk("R1 pc_out", pc_out, 8'h00);
        chk("R1 a_mode", 8'(a_mode), 8'h0);
        chk("R1 dirs", {4'h0, a_is_input, b_is_strobed, b_is_input, 1'b0}, 8'h0A);
        chk("R1 inte", {5'h0, inte_a_rx, inte_a_tx, inte_b}, 8'h00);
        chk("R1 hs_init in reset", 8'(hs_init), 8'h1);
        rst_n = 1'b1;
        chk("R1 hs_init release", 8'(hs_init), 8'h1);
        @(negedge clk);
        chk("R1 hs_init drop", 8'(hs_init), 8'h0);
    endtask

    task automatic t_all_out;
        mode_word(8'h80);
        chk("R5 all out", pc_out_en, 8'hFF);
        chk("R2 a_mode basic", 8'(a_mode), 8'h0);
        pcw(8'hA5);
        chk("R4 direct", pc_out, 8'hA5);
        ctl(8'h7D);
        chk("R3 set bit6 high bits ignored", pc_out, 8'hE5);
        chk("R9 read latch", pc_rd_data, 8'hE5);
    endtask

    task automatic t_split_dir;
        mode_word(8'h88);
        chk("R5 low nibble out", pc_out_en, 8'h0F);
        chk("R6 cleared", pc_out, 8'h00);
        pcw(8'hFF);
        chk("R4 inputs untouched", pc_out, 8'h0F);
        ctl(8'h0F);
        chk("R3 input pos ignored", pc_out, 8'h0F);
        pc_pin_in = 8'h3C; #1;
        chk("R9 mixed read", pc_rd_data, 8'h3F);
    endtask

    task automatic t_strobed_in;
        mode_word(8'hB4);
        chk("R2 a_mode strobed", 8'(a_mode), 8'h1);
        chk("R2 dirs", {4'h0, a_is_input, b_is_strobed, b_is_input, 1'b0}, 8'h0C);
        chk("R5 roles", pc_out_en, 8'hEB);
        chk("R6 obf B", pc_out, 8'h02);
        pcw(8'hFF);
        chk("R4 both nibbles locked", pc_out, 8'h02);
        ctl(8'h0F);
        chk("R3 spare via bsr", pc_out, 8'h82);
        ctl(8'h0B);
        chk("R3 handshake bit", pc_out, 8'hA2);
        ctl(8'h09);
        chk("R7 inte_a_rx", 8'(inte_a_rx), 8'h1);
        chk("R7 latch kept", pc_out, 8'hA2);
        ctl(8'h05);
        chk("R7 inte_b", 8'(inte_b), 8'h1);
        ctl(8'h0D);
        chk("R7 pos6 not inte in rx mode", 8'(inte_a_tx), 8'h0);
        chk("R3 pos6 latch", pc_out, 8'hE2);
        pc_pin_in = 8'h14; #1;
        chk("R9 hs inputs read pins", pc_rd_data, 8'hF6);
        mode_word(8'hB4);
        chk("R7 cleared", {5'h0, inte_a_rx, inte_a_tx, inte_b}, 8'h00);
        chk("R6 rebuild", pc_out, 8'h02);
    endtask

    task automatic t_bidir;
        mode_word(8'hC0);
        chk("R2 a_mode bidir", 8'(a_mode), 8'h2);
        chk("R5 bidir roles", pc_out_en, 8'hAF);
        chk("R6 obf A", pc_out, 8'h80);
        pcw(8'hFF);
        chk("R4 lower spare only", pc_out, 8'h87);
        ctl(8'h0D);
        chk("R7 inte_a_tx", 8'(inte_a_tx), 8'h1);
        ctl(8'h09);
        chk("R7 inte_a_rx bidir", 8'(inte_a_rx), 8'h1);
        chk("R7 latch untouched", pc_out, 8'h87);
        ctl(8'h0E);
        chk("R3 clear obf", pc_out, 8'h07);
        mode_word(8'hE0);
        chk("R2 bits 11 bidir", 8'(a_mode), 8'h2);
        chk("R7 cleared bidir", {5'h0, inte_a_rx, inte_a_tx, inte_b}, 8'h00);
    endtask

    task automatic t_strobed_out;
        mode_word(8'hAB);
        chk("R5 strobed out roles", pc_out_en, 8'h88);
        chk("R6 obf set", pc_out, 8'h80);
        chk("R2 a out", 8'(a_is_input), 8'h0);
        ctl(8'h09);
        chk("R7 pos4 not inte in tx mode", 8'(inte_a_rx), 8'h0);
        chk("R3 pos4 input ignored", pc_out, 8'h80);
        ctl(8'h0D);
        chk("R7 inte_a_tx strobed", 8'(inte_a_tx), 8'h1);
        ctl(8'h07);
        chk("R3 intr bit", pc_out, 8'h88);
    endtask

    task automatic t_collide;
        mode_word(8'h80);
        chk("R6 all cleared", pc_out, 8'h00);
        @(negedge clk); ctrl_wr = 1'b1; portc_wr = 1'b1; wr_data = 8'h0F;
        @(negedge clk); ctrl_wr = 1'b0; portc_wr = 1'b0;
        chk("R10 control wins", pc_out, 8'h80);
        mode_word(8'h86);
        chk("R5 B strobed in", pc_out_en, 8'hFB);
        chk("R6 no obf for input", pc_out, 8'h00);
        pcw(8'hFF);
        chk("R4 lower locked by B", pc_out, 8'hF0);
    endtask

    initial begin
        t_reset;
        t_all_out;
        t_split_dir;
        t_strobed_in;
        t_bidir;
        t_strobed_out;
        t_collide;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule